// File: doc/BRIEF.md
# Debounced Key and GPIO Interrupt Controller

This block watches a vector of general-purpose inputs and turns their settled levels into interrupts. Every monitored input passes through a two-flop synchronizer and a debounce filter. The filter accepts a new level only after that level has held for a programmed number of millisecond ticks. The tick comes from a divider whose clocks-per-millisecond count is set by configuration. A per-input inversion bit decides which electrical level means "pressed". The filtered states drive one keyboard interrupt, which can fire on press, on release or on both, and only enabled inputs take part.

Alongside the keyboard interrupt there are five independent interrupt lines. Each line selects one input by index and fires when that input's debounced state changes (edge mode) or while it is pressed (level mode). All interrupts are sticky. A one-cycle clear pulse removes them, but a new event in the same cycle wins over the clear. Two input positions, set by a parameter mask, are hard-excluded. They never show a pressed state and can never raise any interrupt.

Top module: `keyscan_irq_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `key_irq`, `line_irq` and `key_state` are all zero.
- R2: With `cfg_debounce_ms` = 0, a change on `gpio_in[i]` appears on `key_state[i]` on the third rising clock edge after the change (two synchronizer stages plus the state register).
- R3: A millisecond tick occurs every `cfg_tick_div` clocks (values 0 and 1 give a tick every clock). With `cfg_debounce_ms` = N > 0, `key_state[i]` changes only at a tick, and only once the synchronized pressed level has differed from it during N consecutive ticks. Any return to the current state restarts the count.
- R4: `key_state[i]` is 1 (pressed) when the synchronized input equals NOT `cfg_active_low[i]`. That is, bit 1 makes a low level count as pressed.
- R5: `key_irq` is set when an enabled input's debounced state rises while `cfg_on_press` = 1, or falls while `cfg_on_release` = 1. It sets on the same edge as the `key_state` change.
- R6: An input with `cfg_key_en[i]` = 0 never sets `key_irq`, but its `key_state` bit still tracks it.
- R7: Interrupt flags are sticky. `clr_key` and `clr_line[l]` clear them at the next edge, and a set event in the same cycle takes priority over the clear.
- R8: Line l monitors input `cfg_line_sel[5l+4:5l]`. In edge mode (`cfg_line_level[l]` = 0), `line_irq[l]` is set on the edge where that input's debounced state changes in either direction.
- R9: In level mode (`cfg_line_level[l]` = 1), `line_irq[l]` is set on every edge at which the selected input's debounced state is pressed, so a clear has no effect while it stays pressed.
- R10: A line with `cfg_line_en[l]` = 0 never becomes set.
- R11: Inputs in the exclusion mask (default: inputs 2 and 3) always read 0 on `key_state` and never set `key_irq` or any `line_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | 32 | Raw asynchronous inputs |
| cfg_tick_div | input | 16 | Clocks per millisecond tick |
| cfg_debounce_ms | input | 6 | Debounce time in ticks (0 = bypass) |
| cfg_active_low | input | 32 | Per-input: 1 = low level is pressed |
| cfg_key_en | input | 32 | Per-input keyboard interrupt enable |
| cfg_on_press | input | 1 | Keyboard interrupt on press |
| cfg_on_release | input | 1 | Keyboard interrupt on release |
| cfg_line_sel | input | 25 | Five 5-bit input indexes, line 0 in bits 4:0 |
| cfg_line_en | input | 5 | Per-line enable |
| cfg_line_level | input | 5 | Per-line mode: 0 edge, 1 level |
| clr_key | input | 1 | Clear the keyboard interrupt |
| clr_line | input | 5 | Clear individual line interrupts |
| key_irq | output | 1 | Sticky keyboard interrupt |
| line_irq | output | 5 | Sticky line interrupts |
| key_state | output | 32 | Debounced pressed state per input |

## Verification
The bound checker watches several rules on every cycle. A keyboard flag or a line flag can only disappear through its clear. A disabled line that is low stays low. The keyboard flag can only rise when press or release reporting is on. Excluded inputs never read as pressed. With filtering active, a debounced state may only change right after a tick. Other properties depend on exact time and need directed stimulus, which the bench's scenarios provide: the three-edge bypass latency, a glitch shorter than the debounce window being dropped, level-mode flags surviving a clear, and set-over-clear priority. These are compared against a behavioural model on every clock.

// File: rtl/kdb_pkg.sv
package kdb_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } line_trig_e;
endpackage

// File: rtl/kdb_tick.sv
module kdb_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W:0]   inc;

  always_comb begin
    inc   = {1'b0, cnt_q} + (DIV_W+1)'(1);
    tick  = (inc >= {1'b0, div});
    cnt_d = tick ? '0 : inc[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/kdb_debounce.sv
module kdb_debounce #(
  parameter int DB_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pin,
  input  logic            invert,
  input  logic            tick,
  input  logic [DB_W-1:0] limit,
  output logic            state_q,
  output logic            state_d
);
  logic            sync1_q, sync2_q;
  logic            pressed;
  logic [DB_W-1:0] cnt_q, cnt_d;

  always_comb begin
    pressed = sync2_q ^ invert;
    state_d = state_q;
    cnt_d   = cnt_q;
    if (limit == '0) begin
      state_d = pressed;
      cnt_d   = '0;
    end else if (pressed == state_q) begin
      cnt_d = '0;
    end else if (tick) begin
      if (({1'b0, cnt_q} + (DB_W+1)'(1)) >= {1'b0, limit}) begin
        state_d = pressed;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      state_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      sync1_q <= pin;
      sync2_q <= sync1_q;
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/kdb_line.sv
module kdb_line
  import kdb_pkg::*;
#(
  parameter int N_IN  = 32,
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  line_trig_e       mode,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  input  logic [N_IN-1:0]  db_q,
  input  logic [N_IN-1:0]  db_d,
  output logic             irq
);
  logic hit, irq_d;

  always_comb begin
    if (mode == TRIG_LEVEL) hit = db_d[sel];
    else                    hit = db_d[sel] ^ db_q[sel];
    irq_d = (irq & ~clr) | (enable & hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end
endmodule

// File: rtl/keyscan_irq_ctrl.sv
module keyscan_irq_ctrl
  import kdb_pkg::*;
#(
  parameter int              N_IN      = 32,
  parameter int              N_LINES   = 5,
  parameter int              DB_W      = 6,
  parameter int              DIV_W     = 16,
  parameter int              SEL_W     = $clog2(N_IN),
  parameter logic [N_IN-1:0] EXCL_MASK = N_IN'(32'h0000_000C)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_IN-1:0]          gpio_in,
  input  logic [DIV_W-1:0]         cfg_tick_div,
  input  logic [DB_W-1:0]          cfg_debounce_ms,
  input  logic [N_IN-1:0]          cfg_active_low,
  input  logic [N_IN-1:0]          cfg_key_en,
  input  logic                     cfg_on_press,
  input  logic                     cfg_on_release,
  input  logic [N_LINES*SEL_W-1:0] cfg_line_sel,
  input  logic [N_LINES-1:0]       cfg_line_en,
  input  logic [N_LINES-1:0]       cfg_line_level,
  input  logic                     clr_key,
  input  logic [N_LINES-1:0]       clr_line,
  output logic                     key_irq,
  output logic [N_LINES-1:0]       line_irq,
  output logic [N_IN-1:0]          key_state
);
  logic            tick;
  logic [N_IN-1:0] db_q, db_d;
  logic [N_IN-1:0] rise, fall;
  logic            key_set, key_d;

  kdb_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .div  (cfg_tick_div),
    .tick (tick)
  );

  for (genvar g = 0; g < N_IN; g++) begin : g_in
    if (EXCL_MASK[g]) begin : g_excl
      logic unused_pin;
      assign unused_pin = gpio_in[g] ^ cfg_active_low[g];
      assign db_q[g] = 1'b0;
      assign db_d[g] = 1'b0;
    end else begin : g_deb
      kdb_debounce #(.DB_W(DB_W)) u_deb (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin    (gpio_in[g]),
        .invert (cfg_active_low[g]),
        .tick   (tick),
        .limit  (cfg_debounce_ms),
        .state_q(db_q[g]),
        .state_d(db_d[g])
      );
    end
  end

  always_comb begin
    rise    = db_d & ~db_q & cfg_key_en;
    fall    = ~db_d & db_q & cfg_key_en;
    key_set = (cfg_on_press & (|rise)) | (cfg_on_release & (|fall));
    key_d   = (key_irq & ~clr_key) | key_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) key_irq <= 1'b0;
    else        key_irq <= key_d;
  end

  assign key_state = db_q;

  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    kdb_line #(.N_IN(N_IN), .SEL_W(SEL_W)) u_line (
      .clk   (clk),
      .rst_n (rst_n),
      .enable(cfg_line_en[l]),
      .mode  (line_trig_e'(cfg_line_level[l])),
      .clr   (clr_line[l]),
      .sel   (cfg_line_sel[l*SEL_W +: SEL_W]),
      .db_q  (db_q),
      .db_d  (db_d),
      .irq   (line_irq[l])
    );
  end
endmodule

// File: rtl/kdb_checker.sv
module kdb_checker #(
  parameter int              N_IN      = 32,
  parameter int              N_LINES   = 5,
  parameter int              DB_W      = 6,
  parameter logic [N_IN-1:0] EXCL_MASK = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic [DB_W-1:0]    cfg_debounce_ms,
  input logic [N_IN-1:0]    key_state,
  input logic               key_irq,
  input logic               clr_key,
  input logic [N_LINES-1:0] line_irq,
  input logic [N_LINES-1:0] clr_line,
  input logic [N_LINES-1:0] cfg_line_en,
  input logic               cfg_on_press,
  input logic               cfg_on_release
);
  // R7: keyboard flag only leaves through its clear
  p_key_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (key_irq && !clr_key) |=> key_irq);

  // R7: line flags only leave through their clears
  p_line_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(line_irq & ~clr_line) & ~line_irq) == '0));

  // R10: a disabled, low line stays low
  p_line_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(~line_irq & ~cfg_line_en) & line_irq) == '0));

  // R5: keyboard flag rises only with press or release reporting on
  p_key_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_irq) |-> $past(cfg_on_press | cfg_on_release));

  // R3: with filtering active a debounced state changes only after a tick
  p_change_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(cfg_debounce_ms) != '0) && (key_state != $past(key_state))) |-> $past(tick));

  // R11: excluded inputs never read as pressed
  p_excluded_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (key_state & EXCL_MASK) == '0);
endmodule

bind keyscan_irq_ctrl kdb_checker #(
  .N_IN(N_IN), .N_LINES(N_LINES), .DB_W(DB_W), .EXCL_MASK(EXCL_MASK)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tick           (tick),
  .cfg_debounce_ms(cfg_debounce_ms),
  .key_state      (key_state),
  .key_irq        (key_irq),
  .clr_key        (clr_key),
  .line_irq       (line_irq),
  .clr_line       (clr_line),
  .cfg_line_en    (cfg_line_en),
  .cfg_on_press   (cfg_on_press),
  .cfg_on_release (cfg_on_release)
);

// File: tb/sim_keyscan_irq_ctrl.sv
`timescale 1ns/1ps
module sim_keyscan_irq_ctrl;
  localparam int          N    = 32;
  localparam int          NL   = 5;
  localparam logic [31:0] EXCL = 32'h0000_000C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] gpio_in, cfg_active_low, cfg_key_en;
  logic [15:0] cfg_tick_div;
  logic [5:0]  cfg_debounce_ms;
  logic        cfg_on_press, cfg_on_release, clr_key;
  logic [24:0] cfg_line_sel;
  logic [4:0]  cfg_line_en, cfg_line_level, clr_line;
  logic        key_irq;
  logic [4:0]  line_irq;
  logic [31:0] key_state;

  int    checks = 0;
  int    failures = 0;
  string cur_req = "R1";
  bit    done = 0;

  always #2.5 clk = ~clk;

  keyscan_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .cfg_tick_div(cfg_tick_div),
    .cfg_debounce_ms(cfg_debounce_ms), .cfg_active_low(cfg_active_low),
    .cfg_key_en(cfg_key_en), .cfg_on_press(cfg_on_press), .cfg_on_release(cfg_on_release),
    .cfg_line_sel(cfg_line_sel), .cfg_line_en(cfg_line_en), .cfg_line_level(cfg_line_level),
    .clr_key(clr_key), .clr_line(clr_line), .key_irq(key_irq), .line_irq(line_irq),
    .key_state(key_state)
  );

  // behavioural reference model
  logic [31:0] hist[$];
  int          m_tcnt;
  int          m_cnt[N];
  logic [31:0] m_db;
  logic        m_key;
  logic [4:0]  m_line;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {};
      hist.push_back(32'h0);
      hist.push_back(32'h0);
      m_tcnt = 0;
      for (int i = 0; i < N; i++) m_cnt[i] = 0;
      m_db = '0; m_key = 0; m_line = '0;
    end else begin
      logic [31:0] nd;
      logic        tk, pr, kset;
      tk = (m_tcnt + 1 >= int'(cfg_tick_div));
      nd = m_db;
      for (int i = 0; i < N; i++) begin
        pr = hist[0][i] ^ cfg_active_low[i];
        if (EXCL[i]) nd[i] = 0;
        else if (cfg_debounce_ms == 0) begin nd[i] = pr; m_cnt[i] = 0; end
        else if (pr == m_db[i]) m_cnt[i] = 0;
        else if (tk) begin
          if (m_cnt[i] + 1 >= int'(cfg_debounce_ms)) begin nd[i] = pr; m_cnt[i] = 0; end
          else m_cnt[i] = m_cnt[i] + 1;
        end
      end
      kset = 0;
      for (int i = 0; i < N; i++)
        if (cfg_key_en[i] && nd[i] != m_db[i])
          if ((nd[i] && cfg_on_press) || (!nd[i] && cfg_on_release)) kset = 1;
      m_key = (m_key && !clr_key) || kset;
      for (int l = 0; l < NL; l++) begin
        int  s;
        logic hitl;
        s = int'(cfg_line_sel[l*5 +: 5]);
        hitl = cfg_line_level[l] ? nd[s] : (nd[s] != m_db[s]);
        m_line[l] = (m_line[l] && !clr_line[l]) || (cfg_line_en[l] && hitl);
      end
      m_db = nd;
      m_tcnt = tk ? 0 : m_tcnt + 1;
      hist.push_back(gpio_in);
      void'(hist.pop_front());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (key_irq !== m_key || line_irq !== m_line || key_state !== m_db) begin
        failures++;
        $display("FAIL %s model: act key=%b line=%b state=%h exp key=%b line=%b state=%h",
                 cur_req, key_irq, line_irq, key_state, m_key, m_line, m_db);
      end
    end
  end

  task automatic expect_v(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_clear(input logic k, input logic [4:0] l);
    clr_key = k; clr_line = l;
    step(1);
    clr_key = 0; clr_line = '0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog: act=running exp=finished");
    finish_run();
  end

  initial begin
    rst_n = 0; gpio_in = '0; cfg_tick_div = 16'd4; cfg_debounce_ms = 6'd0;
    cfg_active_low = '0; cfg_key_en = '1; cfg_on_press = 1; cfg_on_release = 0;
    cfg_line_sel = {5'd31, 5'd9, 5'd2, 5'd7, 5'd5};
    cfg_line_en = 5'b10111; cfg_line_level = 5'b00010;
    clr_key = 0; clr_line = '0;
    step(3);
    expect_v("R1", {26'h0, key_irq, line_irq}, 32'h0);
    expect_v("R1", key_state, 32'h0);
    rst_n = 1;
    step(1);
    expect_v("R1", {26'h0, key_irq, line_irq}, 32'h0);

    // R2: bypass latency of three edges
    cur_req = "R2";
    gpio_in[0] = 1;
    step(2);
    expect_v("R2", key_state[0], 0);
    step(1);
    expect_v("R2", key_state[0], 1);
    expect_v("R5", key_irq, 1);
    pulse_clear(1, '0);
    step(1);
    expect_v("R7", key_irq, 0);

    // R3: glitch rejected, stable level accepted
    cur_req = "R3";
    cfg_debounce_ms = 6'd3;
    gpio_in[5] = 1; step(6); gpio_in[5] = 0; step(20);
    expect_v("R3", key_state[5], 0);
    expect_v("R8", line_irq[0], 0);
    gpio_in[5] = 1; step(30);
    expect_v("R3", key_state[5], 1);
    expect_v("R8", line_irq[0], 1);

    // R4 / R9: inverted input in level mode
    cur_req = "R4";
    cfg_active_low[7] = 1; step(30);
    expect_v("R4", key_state[7], 1);
    expect_v("R9", line_irq[1], 1);
    cur_req = "R9";
    pulse_clear(0, 5'b00010); step(1);
    expect_v("R9", line_irq[1], 1);
    gpio_in[7] = 1; step(30);
    expect_v("R4", key_state[7], 0);
    pulse_clear(0, 5'b00010); step(1);
    expect_v("R9", line_irq[1], 0);

    // R5: release-only reporting, R8 edge on fall
    cur_req = "R5";
    pulse_clear(1, 5'b00001);
    cfg_on_press = 0; cfg_on_release = 1;
    gpio_in[10] = 1; step(30);
    expect_v("R5", key_irq, 0);
    gpio_in[0] = 0; gpio_in[5] = 0; step(30);
    expect_v("R5", key_irq, 1);
    expect_v("R8", line_irq[0], 1);

    // R6 / R10: masked key, disabled line
    cur_req = "R6";
    cfg_on_press = 1;
    cfg_key_en = ~32'h0000_0200;
    pulse_clear(1, 5'b11111);
    gpio_in[9] = 1; step(30);
    expect_v("R6", key_state[9], 1);
    expect_v("R6", key_irq, 0);
    expect_v("R10", line_irq[3], 0);

    // R11: excluded inputs
    cur_req = "R11";
    gpio_in[2] = 1; gpio_in[3] = 1; step(30);
    expect_v("R11", key_state & EXCL, 32'h0);
    expect_v("R11", {31'h0, key_irq}, 32'h0);
    expect_v("R11", line_irq[2], 0);

    // R7: set wins over a simultaneous clear
    cur_req = "R7";
    cfg_debounce_ms = 6'd0;
    clr_key = 1; clr_line = 5'b10000;
    gpio_in[12] = 1; gpio_in[31] = 1;
    step(3);
    expect_v("R7", key_irq, 1);
    expect_v("R7", line_irq[4], 1);
    clr_key = 0; clr_line = '0;
    step(2);

    // R3: tick every clock, long window
    cur_req = "R3";
    cfg_tick_div = 16'd0; cfg_debounce_ms = 6'd63;
    gpio_in[20] = 1; step(40);
    expect_v("R3", key_state[20], 0);
    step(30);
    expect_v("R3", key_state[20], 1);
    cfg_tick_div = 16'd2; cfg_debounce_ms = 6'd1;
    gpio_in[20] = 0; step(8);
    expect_v("R3", key_state[20], 0);
    step(2);
    finish_run();
  end
endmodule